// File: doc/BRIEF.md
# Thermal Limit Event Generator

This block watches a stream of signed temperature samples. It compares each held reading against three programmable thresholds: an upper alarm, a lower alarm and a critical ceiling. From that comparison it produces three trip flags, an event-status bit and the level of an open-drain style event line. A host programs the thresholds and a 16-bit control word over a small register bus with a write strobe and an address-decoded read port. Samples arrive on a valid-qualified input. The analog front end and the serial bus that would carry register traffic sit outside the block.

The control word sets the following behaviour:

- The event either follows the live compare result (comparator mode) or latches until software clears it (interrupt mode).
- The line can be active-low or active-high, and it can be enabled or disabled.
- Alarms can be restricted to the critical threshold only.
- Hysteresis can be applied when flags de-assert.
- A shutdown bit stops the block from accepting new samples.
- Two sticky lock bits freeze the thresholds and the mode fields until reset.

Top module: `tevt_event_gen`

## Requirements
- R1: After synchronous reset the control word and all three thresholds read 0x0000, so the line is disabled and active-low and `evt_level` is 1 (released).
- R2: Register addresses are 0 control, 1 upper alarm, 2 lower alarm, 3 critical, 4 temperature word. A threshold keeps only write bits 12:2 (two's complement, 0.25 °C per step in bit 2) and reads 0 in bits 15:13 and 1:0. The temperature word reads {critical flag, upper flag, lower flag, 13-bit sample}.
- R3: Samples are 13-bit two's complement in 1/16 °C. The critical flag (read bit 15, `trip_flags[2]`) sets when the reading is at or above critical. The upper flag (bit 14, `trip_flags[1]`) sets when the reading is strictly above the upper alarm. The lower flag (bit 13, `trip_flags[0]`) sets when the reading is strictly below the lower alarm.
- R4: Control bits 10:9 select a de-assert hysteresis of 0, 24, 48 or 96 sixteenths (codes 00/01/10/11). A set flag clears only once the reading has moved back past its threshold by that amount.
- R5: With control bit 0 at 0 (comparator mode), the event status follows the current flags and drops once no flag holds.
- R6: With control bit 0 at 1 (interrupt mode), an alarm flag rising latches the event. Writing 1 to control bit 5 clears the latch. In comparator mode that write has no effect on the status.
- R7: A set critical flag forces the event status to 1 in either mode. A clear written while the critical flag is set is ignored, and the latch survives it. With control bit 2 set, only the critical flag raises an event.
- R8: The event status reads in control bit 4 whatever the line settings are. The line is asserted when status is 1 and enable (bit 3) is 1. Bit 1 selects active-high (1) or active-low (0). A disabled line sits at 1 when active-low and at 0 when active-high.
- R9: A threshold write that creates a trip condition raises the event without any new sample.
- R10: Bit 7 locks the critical threshold and bit 6 locks both alarm thresholds. Neither lock clears except by reset. While either lock is set, bits 0, 1, 3 and 10:9 keep their values and bit 8 cannot be set, although it can be cleared. Bit 2 cannot be set while bit 6 is set.
- R11: While bit 8 (shutdown) is set, samples are ignored and the last reading is held.
- R12: On entering shutdown the event status is cleared (default build) and stays 0 until shutdown ends.
- R13: Bits 15:11 and bit 5 of the control word always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for writes and reads |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| smp_valid | input | 1 | Sample strobe |
| smp_temp | input | 13 | Signed sample, 1/16 °C |
| evt_level | output | 1 | Resolved event line level |
| evt_sts | output | 1 | Event status (asserted state, polarity-free) |
| trip_flags | output | 3 | {critical, upper, lower} trip flags |

## Verification
A wrong hysteresis or trip state shows up on `trip_flags` and in the temperature word within two cycles of the sample or threshold write that should have moved it. A latch that fails to set or clear shows as a wrong `evt_sts` a cycle later, and it persists across further samples in interrupt mode, so a wrong latch state remains visible. Lock or merge mistakes are exposed only by reading the control word or a threshold back after a refused write, so every refused write is followed at once by a read-back.

// File: rtl/tevt_pkg.sv
package tevt_pkg;

    localparam int TEMP_W = 13;
    localparam int REG_W  = 16;
    localparam int HYST_W = 8;

    typedef logic signed [TEMP_W-1:0] temp_t;

    typedef struct packed {
        logic [4:0] rsvd;
        logic [1:0] hyst;
        logic       shdn;
        logic       crit_lock;
        logic       alm_lock;
        logic       clr;
        logic       sts;
        logic       ena;
        logic       crit_only;
        logic       pol;
        logic       irq_mode;
    } cfg_t;

    typedef struct packed {
        logic crit;
        logic high;
        logic low;
    } trip_t;

    typedef enum logic [1:0] {
        CMP_CRIT = 2'd0,
        CMP_HIGH = 2'd1,
        CMP_LOW  = 2'd2
    } cmp_kind_e;

    typedef enum logic [2:0] {
        RA_CFG  = 3'd0,
        RA_HIGH = 3'd1,
        RA_LOW  = 3'd2,
        RA_CRIT = 3'd3,
        RA_TEMP = 3'd4
    } reg_addr_e;

    function automatic logic [HYST_W-1:0] hyst_steps(input logic [1:0] sel);
        case (sel)
            2'b01:   return HYST_W'(24);
            2'b10:   return HYST_W'(48);
            2'b11:   return HYST_W'(96);
            default: return '0;
        endcase
    endfunction

    function automatic cfg_t cfg_merge(input cfg_t cur, input cfg_t wr);
        cfg_t nxt;
        logic locked;
        nxt       = cur;
        locked    = cur.crit_lock | cur.alm_lock;
        nxt.crit_lock = cur.crit_lock | wr.crit_lock;
        nxt.alm_lock  = cur.alm_lock  | wr.alm_lock;
        if (!locked) begin
            nxt.irq_mode = wr.irq_mode;
            nxt.pol      = wr.pol;
            nxt.ena      = wr.ena;
            nxt.hyst     = wr.hyst;
            nxt.shdn     = wr.shdn;
        end else begin
            nxt.shdn     = cur.shdn & wr.shdn;
        end
        if (cur.alm_lock)
            nxt.crit_only = cur.crit_only & wr.crit_only;
        else
            nxt.crit_only = wr.crit_only;
        nxt.rsvd = '0;
        nxt.clr  = 1'b0;
        nxt.sts  = 1'b0;
        return nxt;
    endfunction

endpackage

// File: rtl/tevt_cfg_regs.sv
module tevt_cfg_regs
    import tevt_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output cfg_t              cfg_q,
    output temp_t             lim_high,
    output temp_t             lim_low,
    output temp_t             lim_crit,
    output logic              clr_req
);
    localparam int LF_W = TEMP_W - 2;

    logic [LF_W-1:0] high_q, low_q, crit_q;
    cfg_t wr_cfg;
    logic sel_cfg, sel_high, sel_low, sel_crit;

    always_comb begin
        wr_cfg   = cfg_t'(bus_wdata);
        sel_cfg  = bus_wr && (bus_addr == ADDR_W'(RA_CFG));
        sel_high = bus_wr && (bus_addr == ADDR_W'(RA_HIGH));
        sel_low  = bus_wr && (bus_addr == ADDR_W'(RA_LOW));
        sel_crit = bus_wr && (bus_addr == ADDR_W'(RA_CRIT));
        clr_req  = sel_cfg && wr_cfg.clr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            high_q <= '0;
            low_q  <= '0;
            crit_q <= '0;
        end else begin
            if (sel_cfg)
                cfg_q <= cfg_merge(cfg_q, wr_cfg);
            if (sel_high && !cfg_q.alm_lock)
                high_q <= bus_wdata[TEMP_W-1:2];
            if (sel_low && !cfg_q.alm_lock)
                low_q <= bus_wdata[TEMP_W-1:2];
            if (sel_crit && !cfg_q.crit_lock)
                crit_q <= bus_wdata[TEMP_W-1:2];
        end
    end

    assign lim_high = temp_t'({high_q, 2'b00});
    assign lim_low  = temp_t'({low_q,  2'b00});
    assign lim_crit = temp_t'({crit_q, 2'b00});

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.crit_lock || cfg_q.alm_lock) |=>
            (cfg_q.crit_lock >= $past(cfg_q.crit_lock)) && (cfg_q.alm_lock >= $past(cfg_q.alm_lock))); // R10
    AST_ALARM_LIMITS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        cfg_q.alm_lock |=> $stable(lim_high) && $stable(lim_low)); // R10
    AST_CRIT_LIMIT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        cfg_q.crit_lock |=> $stable(lim_crit)); // R10

endmodule

// File: rtl/tevt_limit_cmp.sv
module tevt_limit_cmp
    import tevt_pkg::*;
#(
    parameter cmp_kind_e KIND = CMP_HIGH
) (
    input  logic              clk,
    input  logic              rst,
    input  temp_t             temp,
    input  temp_t             limit,
    input  logic [HYST_W-1:0] hyst,
    output logic              flag
);
    localparam int EW = TEMP_W + 2;

    logic signed [EW-1:0] t_x, l_x, h_x;
    logic set_c, clr_c;

    always_comb begin
        t_x = EW'(temp);
        l_x = EW'(limit);
        h_x = $signed({{(EW-HYST_W){1'b0}}, hyst});
    end

    generate
        if (KIND == CMP_CRIT) begin : g_crit
            always_comb begin
                set_c = (t_x >= l_x);
                clr_c = (t_x < (l_x - h_x));
            end
        end else if (KIND == CMP_HIGH) begin : g_high
            always_comb begin
                set_c = (t_x > l_x);
                clr_c = (t_x <= (l_x - h_x));
            end
        end else begin : g_low
            always_comb begin
                set_c = (t_x < l_x);
                clr_c = (t_x >= (l_x + h_x));
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else
            flag <= set_c | (flag & ~clr_c);
    end

    AST_FLAG_STABLE_INPUTS: assert property (@(posedge clk) disable iff (rst)
        (flag && $stable(temp) && $stable(limit) && $stable(hyst)) |=> flag); // R4

endmodule

// File: rtl/tevt_event_ctl.sv
module tevt_event_ctl
    import tevt_pkg::*;
#(
    parameter bit SHDN_CLEARS = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  cfg_t  cfg,
    input  trip_t trip,
    input  logic  clr_req,
    output logic  evt_sts,
    output logic  evt_level
);
    logic alarm_prev, alarm_latch, shdn_prev;
    logic alarm_cond, alarm_rise, latch_next, sts_next, shdn_drop, asserted;

    generate
        if (SHDN_CLEARS) begin : g_shdn_clear
            assign shdn_drop = cfg.shdn & ~shdn_prev;
        end else begin : g_shdn_freeze
            assign shdn_drop = 1'b0;
        end
    endgenerate

    always_comb begin
        alarm_cond = trip.high | trip.low;
        alarm_rise = alarm_cond & ~alarm_prev;
        if (!cfg.irq_mode)
            latch_next = 1'b0;
        else if (alarm_rise)
            latch_next = 1'b1;
        else if (clr_req && !trip.crit && !cfg.shdn)
            latch_next = 1'b0;
        else
            latch_next = alarm_latch;

        if (cfg.shdn)
            sts_next = shdn_drop ? 1'b0 : evt_sts;
        else
            sts_next = trip.crit |
                       (~cfg.crit_only & (cfg.irq_mode ? latch_next : alarm_cond));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_prev  <= 1'b0;
            alarm_latch <= 1'b0;
            shdn_prev   <= 1'b0;
            evt_sts     <= 1'b0;
        end else begin
            alarm_prev  <= alarm_cond;
            alarm_latch <= latch_next;
            shdn_prev   <= cfg.shdn;
            evt_sts     <= sts_next;
        end
    end

    assign asserted  = evt_sts & cfg.ena;
    assign evt_level = cfg.pol ? asserted : ~asserted;

    AST_CRIT_FORCES_EVENT: assert property (@(posedge clk) disable iff (rst)
        (trip.crit && !cfg.shdn) |=> evt_sts); // R7
    AST_CMP_MODE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!cfg.irq_mode && !cfg.shdn && !trip.crit && !trip.high && !trip.low) |=> !evt_sts); // R5
    AST_DISABLED_LINE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cfg.ena |-> (evt_level == !cfg.pol)); // R8
    AST_SHDN_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        (cfg.shdn && $past(cfg.shdn) && !evt_sts) |=> !evt_sts); // R12

endmodule

// File: rtl/tevt_event_gen.sv
module tevt_event_gen
    import tevt_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter bit SHDN_CLEARS = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              smp_valid,
    input  logic [12:0]       smp_temp,
    output logic              evt_level,
    output logic              evt_sts,
    output logic [2:0]        trip_flags
);
    localparam int NCMP = 3;

    cfg_t  cfg_q, cfg_rd;
    temp_t lim_high, lim_low, lim_crit, temp_q;
    logic  clr_req;
    trip_t trip;
    temp_t lims [NCMP];
    logic [NCMP-1:0] flags;
    logic [HYST_W-1:0] hyst_amt;

    tevt_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cfg_q     (cfg_q),
        .lim_high  (lim_high),
        .lim_low   (lim_low),
        .lim_crit  (lim_crit),
        .clr_req   (clr_req)
    );

    always_ff @(posedge clk) begin
        if (rst)
            temp_q <= '0;
        else if (smp_valid && !cfg_q.shdn)
            temp_q <= temp_t'(smp_temp);
    end

    assign hyst_amt = hyst_steps(cfg_q.hyst);
    assign lims[CMP_CRIT] = lim_crit;
    assign lims[CMP_HIGH] = lim_high;
    assign lims[CMP_LOW]  = lim_low;

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        tevt_limit_cmp #(.KIND(cmp_kind_e'(g))) u_cmp (
            .clk   (clk),
            .rst   (rst),
            .temp  (temp_q),
            .limit (lims[g]),
            .hyst  (hyst_amt),
            .flag  (flags[g])
        );
    end

    assign trip = '{crit: flags[CMP_CRIT], high: flags[CMP_HIGH], low: flags[CMP_LOW]};

    tevt_event_ctl #(.SHDN_CLEARS(SHDN_CLEARS)) u_evt (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg_q),
        .trip      (trip),
        .clr_req   (clr_req),
        .evt_sts   (evt_sts),
        .evt_level (evt_level)
    );

    always_comb begin
        cfg_rd     = cfg_q;
        cfg_rd.sts = evt_sts;
        case (bus_addr)
            ADDR_W'(RA_CFG):  bus_rdata = cfg_rd;
            ADDR_W'(RA_HIGH): bus_rdata = {{(REG_W-TEMP_W){1'b0}}, lim_high};
            ADDR_W'(RA_LOW):  bus_rdata = {{(REG_W-TEMP_W){1'b0}}, lim_low};
            ADDR_W'(RA_CRIT): bus_rdata = {{(REG_W-TEMP_W){1'b0}}, lim_crit};
            ADDR_W'(RA_TEMP): bus_rdata = {trip, temp_q};
            default:          bus_rdata = '0;
        endcase
    end

    assign trip_flags = trip;

    AST_SHDN_HOLDS_TEMP: assert property (@(posedge clk) disable iff (rst)
        cfg_q.shdn |=> $stable(temp_q)); // R11
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(RA_CFG)) |-> (bus_rdata[15:11] == 5'd0) && !bus_rdata[5]); // R13

endmodule

// File: tb/tevt_event_gen_tb.sv
`timescale 1ns/1ps
module tevt_event_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        smp_valid = 1'b0;
    logic [12:0] smp_temp = 13'h0;
    logic        evt_level, evt_sts;
    logic [2:0]  trip_flags;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    tevt_event_gen u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_valid(smp_valid),
        .smp_temp(smp_temp), .evt_level(evt_level), .evt_sts(evt_sts),
        .trip_flags(trip_flags)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        settle();
    endtask

    task automatic smp(input logic [12:0] t);
        @(negedge clk);
        smp_valid = 1'b1; smp_temp = t;
        @(negedge clk);
        smp_valid = 1'b0;
        settle();
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_limits();
        wr(3'd1, 16'h0500);
        wr(3'd2, 16'h0140);
        wr(3'd3, 16'h0600);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        do_reset();
        check("R1 line released after reset", {15'd0, evt_level}, 16'h1);
        rd(3'd0, d); check("R1 control word reset", d & 16'hFFEF, 16'h0000);
        rd(3'd1, d); check("R1 upper threshold reset", d, 16'h0000);
        rd(3'd3, d); check("R1 critical threshold reset", d, 16'h0000);
    endtask

    task automatic t_regmap();
        logic [15:0] d;
        do_reset();
        wr(3'd1, 16'hE507);
        rd(3'd1, d); check("R2 threshold field masking", d, 16'h0504);
        wr(3'd2, 16'h1FFF);
        rd(3'd2, d); check("R2 lower threshold negative", d, 16'h1FFC);
        wr(3'd0, 16'hF830);
        rd(3'd0, d); check("R13 reserved and clear bits read 0", d & 16'hFFEF, 16'h0000);
    endtask

    task automatic t_trip();
        logic [15:0] d;
        do_reset(); set_limits();
        wr(3'd0, 16'h0008);
        smp(13'h0320);
        check("R3 no flag mid-band", {13'd0, trip_flags}, 16'h0);
        check("R5 status low mid-band", {15'd0, evt_sts}, 16'h0);
        check("R8 active-low idle level", {15'd0, evt_level}, 16'h1);
        smp(13'h0510);
        check("R3 upper flag above", {13'd0, trip_flags}, 16'h2);
        check("R5 status follows upper", {15'd0, evt_sts}, 16'h1);
        check("R8 active-low asserted level", {15'd0, evt_level}, 16'h0);
        smp(13'h0500);
        check("R3 equal to upper is not above", {13'd0, trip_flags}, 16'h0);
        check("R5 status drops", {15'd0, evt_sts}, 16'h0);
        smp(13'h1F00);
        rd(3'd4, d); check("R3 negative reading trips lower", d, 16'h3F00);
        smp(13'h0600);
        rd(3'd4, d); check("R3 critical at equality", d, 16'hC600);
    endtask

    task automatic t_hyst();
        do_reset(); set_limits();
        wr(3'd0, 16'h0208);
        smp(13'h0510);
        check("R4 upper set", {13'd0, trip_flags}, 16'h2);
        smp(13'h04F0);
        check("R4 held inside band", {13'd0, trip_flags}, 16'h2);
        smp(13'h04E8);
        check("R4 clears past band", {13'd0, trip_flags}, 16'h0);
    endtask

    task automatic t_irq();
        do_reset(); set_limits();
        smp(13'h0320);
        wr(3'd0, 16'h0009);
        smp(13'h0510);
        check("R6 latch on rise", {15'd0, evt_sts}, 16'h1);
        smp(13'h0320);
        check("R6 latch holds after return", {15'd0, evt_sts}, 16'h1);
        wr(3'd0, 16'h0029);
        check("R6 write-one clear", {15'd0, evt_sts}, 16'h0);
        smp(13'h0610);
        check("R7 critical raises event", {15'd0, evt_sts}, 16'h1);
        wr(3'd0, 16'h0029);
        check("R7 clear ignored above critical", {15'd0, evt_sts}, 16'h1);
        smp(13'h0320);
        check("R7 latch survives ignored clear", {15'd0, evt_sts}, 16'h1);
        wr(3'd0, 16'h0008);
        smp(13'h0510);
        wr(3'd0, 16'h0028);
        check("R6 clear no effect in comparator mode", {15'd0, evt_sts}, 16'h1);
        wr(3'd0, 16'h000C);
        check("R7 critical-only masks alarm", {15'd0, evt_sts}, 16'h0);
        smp(13'h0610);
        check("R7 critical-only still trips", {15'd0, evt_sts}, 16'h1);
    endtask

    task automatic t_pol();
        logic [15:0] d;
        do_reset(); set_limits();
        wr(3'd0, 16'h000A);
        smp(13'h0510);
        check("R8 active-high asserted", {15'd0, evt_level}, 16'h1);
        wr(3'd0, 16'h0002);
        check("R8 disabled active-high idles low", {15'd0, evt_level}, 16'h0);
        rd(3'd0, d); check("R8 status visible while disabled", d, 16'h0012);
        wr(3'd0, 16'h0000);
        check("R8 disabled active-low released", {15'd0, evt_level}, 16'h1);
        wr(3'd0, 16'h000A);
        smp(13'h0320);
        check("R8 active-high deasserted", {15'd0, evt_level}, 16'h0);
    endtask

    task automatic t_limwr();
        do_reset(); set_limits();
        wr(3'd0, 16'h0008);
        smp(13'h0320);
        wr(3'd1, 16'h0300);
        check("R9 threshold write trips without sample", {15'd0, evt_sts}, 16'h1);
        check("R9 line asserts", {15'd0, evt_level}, 16'h0);
    endtask

    task automatic t_shdn();
        logic [15:0] d;
        do_reset(); set_limits();
        wr(3'd0, 16'h0008);
        smp(13'h0510);
        wr(3'd0, 16'h0108);
        check("R12 status cleared at shutdown", {15'd0, evt_sts}, 16'h0);
        smp(13'h0200);
        rd(3'd4, d); check("R11 reading held", d, 16'h4510);
        check("R12 status stays clear", {15'd0, evt_sts}, 16'h0);
        wr(3'd0, 16'h0008);
        check("R11 resume status", {15'd0, evt_sts}, 16'h1);
        smp(13'h0200);
        rd(3'd4, d); check("R11 new sample accepted", d, 16'h0200);
    endtask

    task automatic t_locks();
        logic [15:0] d;
        do_reset();
        wr(3'd1, 16'h0500);
        wr(3'd0, 16'h00C8);
        wr(3'd1, 16'h0100);
        rd(3'd1, d); check("R10 upper frozen by alarm lock", d, 16'h0500);
        wr(3'd3, 16'h0300);
        rd(3'd3, d); check("R10 critical frozen", d, 16'h0000);
        wr(3'd0, 16'h0003);
        rd(3'd0, d); check("R10 locks and mode fields kept", d & 16'hFFEF, 16'h00C8);
        wr(3'd0, 16'h01CC);
        rd(3'd0, d); check("R10 shutdown and critical-only not set", d & 16'hFFEF, 16'h00C8);
        do_reset();
        wr(3'd0, 16'h0108);
        wr(3'd0, 16'h0148);
        wr(3'd0, 16'h0040);
        rd(3'd0, d); check("R10 shutdown cleared under lock", d & 16'hFFEF, 16'h0048);
        do_reset();
        wr(3'd0, 16'h0080);
        wr(3'd3, 16'h0600);
        rd(3'd3, d); check("R10 critical lock alone", d, 16'h0000);
        wr(3'd1, 16'h0500);
        rd(3'd1, d); check("R10 upper still writable", d, 16'h0500);
        do_reset();
        rd(3'd0, d); check("R10 locks released by reset", d & 16'hFFEF, 16'h0000);
    endtask

    initial begin : watchdog
        #800000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_regmap();
        t_trip();
        t_hyst();
        t_irq();
        t_pol();
        t_limwr();
        t_shdn();
        t_locks();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule